// File: doc/BRIEF.md
# Ethernet receive frame error classifier

This block sits beside a byte-wide receive datapath and gives every frame a verdict: one error flag and an 8-bit error code. It counts the bytes of each frame, captures the type/length field of the L2 header, and at end of frame weighs the count against configurable minimum, maximum and skip limits, against a fixed truncation limit and against the length field. It then combines that with the FCS status, the receive-error strobe, a buffer-overflow indication and a non-whole-byte (dribble) indication.

The CRC engine and the frame buffer stay outside. FCS validity and the dribble indication are sampled on the last byte of a frame. The verdict appears one clock after that last byte, as a one-cycle pulse. Frames may follow each other with no idle cycle between them.

Top module: `rx_frame_classifier`

## Requirements
- R1: `res_valid` pulses for exactly the cycle after each beat with `in_valid` and `in_last` high, and is low otherwise. `res_err` is 1 exactly when `res_code` is nonzero. While `res_valid` is low, `res_code` and `res_err` are 0.
- R2: If `in_ovf` is high on any valid beat of the frame, the code is 1 (partial), whatever else holds.
- R3: A frame with more than `JABBER_LEN` bytes (default 1536) gives code 2 (truncated), unless R2 applies.
- R4: If `in_rxerr` is high on any valid beat of the frame, the code is 11, unless R2 or R3 applies.
- R5: A byte count above `cfg_max_len` gives code 3 when `in_fcs_ok` is 0 at the last byte, and code 4 when it is 1.
- R6: If `in_dribble` is 1 and `in_fcs_ok` is 0 at the last byte, the code is 5 (alignment). Dribble with a good FCS has no effect on the code.
- R7: A byte count below `cfg_min_len` gives code 6 with a bad FCS and code 8 with a good FCS.
- R8: A byte count below `cfg_skip` gives code 12.
- R9: A byte count below 14 (the L2 header) gives code 18.
- R10: The length field is the 16-bit value in bytes 12 (high) and 13 (low), counting from byte 0. When it is below 0x0600 and the field plus 18 differs from the byte count, the code is 10. A field of 0x0600 or above is a type and is not checked.
- R11: An otherwise clean frame with `in_fcs_ok` 0 gives code 7. A clean frame with a good FCS gives code 0.
- R12: When several conditions hold, the lowest entry of this list wins: partial, truncated, receive error, overrun, oversize, alignment, fragment, undersize, skip, L2 short, length mismatch, FCS.
- R13: The byte count and the sticky receive-error and overflow state clear at every end of frame, so no status carries into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_rxerr | input | 1 | Receive-error strobe, sampled with `in_valid` |
| in_ovf | input | 1 | Buffer overflow, sampled with `in_valid` |
| in_last | input | 1 | This byte is the last of the frame |
| in_fcs_ok | input | 1 | FCS good, sampled with the last byte |
| in_dribble | input | 1 | Frame not a whole number of bytes, sampled with the last byte |
| cfg_skip | input | 8 | Minimum bytes needed to cover the skipped region |
| cfg_min_len | input | 16 | Minimum legal frame length in bytes |
| cfg_max_len | input | 16 | Maximum legal frame length in bytes |
| res_valid | output | 1 | Verdict valid (one cycle) |
| res_err | output | 1 | Verdict is an error |
| res_code | output | 8 | Error code |

## Verification
Frames are sent at lengths just inside and just outside each limit (min, max, truncation, skip, 14 bytes), each with good and bad FCS. This separates the FCS-combined code pairs 3/4 and 6/8 and shows where each comparison boundary lies. Frames with several faults at once (overflow with truncation, receive error with overrun, dribble on a short frame, a length mismatch with a bad FCS) check the priority order. Clean frames sent back-to-back right after faulty ones show that no status carries over, and a type field of 0x0600 against 0x05FF shows where the length check starts.

// File: rtl/rxc_pkg.sv
// Shared code values for the receive frame classifier.
package rxc_pkg;
    typedef enum logic [7:0] {
        RXC_OK        = 8'd0,
        RXC_PARTIAL   = 8'd1,
        RXC_TRUNC     = 8'd2,
        RXC_OVERRUN   = 8'd3,
        RXC_OVERSIZE  = 8'd4,
        RXC_ALIGN     = 8'd5,
        RXC_FRAGMENT  = 8'd6,
        RXC_FCS       = 8'd7,
        RXC_UNDERSIZE = 8'd8,
        RXC_LEN_MISM  = 8'd10,
        RXC_RX_ERR    = 8'd11,
        RXC_SKIP      = 8'd12,
        RXC_L2_SHORT  = 8'd18
    } rxc_code_e;
endpackage

// File: rtl/rxc_frame_tracker.sv
// Byte counter and sticky flags for the frame in progress.
// Assumes: in_last is only meaningful with in_valid. Outputs the count
// including the current byte and the flags including the current beat.
module rxc_frame_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_rxerr,
    input  logic             in_ovf,
    output logic [CNT_W-1:0] cnt_prev,
    output logic [CNT_W-1:0] cnt_now,
    output logic             rxerr_now,
    output logic             ovf_now
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             rxerr_q;
    logic             ovf_q;

    // Count including this byte, saturating at the top.
    always_comb begin
        cnt_now   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        rxerr_now = rxerr_q | in_rxerr;
        ovf_now   = ovf_q | in_ovf;
        cnt_prev  = cnt_q;
    end

    // Advance the count and sticky flags per byte; clear at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rxerr_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (in_valid) begin
            if (in_last) begin
                cnt_q   <= '0;
                rxerr_q <= 1'b0;
                ovf_q   <= 1'b0;
            end else begin
                cnt_q   <= cnt_now;
                rxerr_q <= rxerr_now;
                ovf_q   <= ovf_now;
            end
        end
    end

    // R13: nothing survives an end of frame.
    assert_state_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (cnt_q == '0 && !rxerr_q && !ovf_q));
endmodule

// File: rtl/rxc_len_field.sv
// Captures the type/length field at byte offsets 12 (high) and 13 (low).
// Assumes cnt_prev is the index of the current byte. The field is only
// meaningful when the frame has reached 14 bytes.
module rxc_len_field #(
    parameter int CNT_W   = 16,
    parameter int HI_IDX  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [CNT_W-1:0] cnt_prev,
    output logic [15:0]      field_now
);
    localparam logic [CNT_W-1:0] HI_POS = CNT_W'(HI_IDX);
    localparam logic [CNT_W-1:0] LO_POS = CNT_W'(HI_IDX + 1);

    logic [7:0] hi_q;
    logic [7:0] lo_q;

    // Latch the two field bytes as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (in_valid) begin
            if (cnt_prev == HI_POS) hi_q <= in_data;
            if (cnt_prev == LO_POS) lo_q <= in_data;
        end
    end

    // Forward the low byte when the frame ends on it.
    always_comb begin
        field_now = {hi_q, (cnt_prev == LO_POS) ? in_data : lo_q};
    end
endmodule

// File: rtl/rxc_verdict.sv
// Priority encoder from frame conditions to an error code.
// Purely combinational; evaluated on the last byte of a frame.
module rxc_verdict
    import rxc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SKIP_W     = 8,
    parameter int JABBER_LEN = 1536,
    parameter int HDR_BYTES  = 14,
    parameter int FCS_BYTES  = 4,
    parameter int TYPE_MIN   = 16'h0600
) (
    input  logic [CNT_W-1:0]  n_bytes,
    input  logic              ovf,
    input  logic              rxerr,
    input  logic              fcs_ok,
    input  logic              dribble,
    input  logic [15:0]       field,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic [CNT_W-1:0]  cfg_min_len,
    input  logic [CNT_W-1:0]  cfg_max_len,
    output rxc_code_e         code
);
    localparam int EXT_W = (CNT_W > 16 ? CNT_W : 16) + 1;
    localparam logic [EXT_W-1:0] OVERHEAD = EXT_W'(HDR_BYTES + FCS_BYTES);

    logic too_long, too_short, short_skip, short_hdr, mism, trunc;

    // Length comparisons.
    always_comb begin
        trunc      = {1'b0, n_bytes} > (CNT_W+1)'(JABBER_LEN);
        too_long   = n_bytes > cfg_max_len;
        too_short  = n_bytes < cfg_min_len;
        short_skip = n_bytes < CNT_W'(cfg_skip);
        short_hdr  = n_bytes < CNT_W'(HDR_BYTES);
        mism       = (field < 16'(TYPE_MIN)) &&
                     ((EXT_W'(field) + OVERHEAD) != EXT_W'(n_bytes));
    end

    // Fixed priority: the earlier test wins.
    always_comb begin
        if (ovf)                   code = RXC_PARTIAL;
        else if (trunc)            code = RXC_TRUNC;
        else if (rxerr)            code = RXC_RX_ERR;
        else if (too_long)         code = fcs_ok ? RXC_OVERSIZE : RXC_OVERRUN;
        else if (dribble && !fcs_ok) code = RXC_ALIGN;
        else if (too_short)        code = fcs_ok ? RXC_UNDERSIZE : RXC_FRAGMENT;
        else if (short_skip)       code = RXC_SKIP;
        else if (short_hdr)        code = RXC_L2_SHORT;
        else if (mism)             code = RXC_LEN_MISM;
        else if (!fcs_ok)          code = RXC_FCS;
        else                       code = RXC_OK;
    end
endmodule

// File: rtl/rx_frame_classifier.sv
// Per-frame receive error classifier. Watches a byte stream, and one
// cycle after each last byte emits a one-cycle verdict with an error
// code. Assumes in_fcs_ok and in_dribble are valid with the last byte.
module rx_frame_classifier
    import rxc_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SKIP_W     = 8,
    parameter int JABBER_LEN = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_rxerr,
    input  logic              in_ovf,
    input  logic              in_last,
    input  logic              in_fcs_ok,
    input  logic              in_dribble,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic [CNT_W-1:0]  cfg_min_len,
    input  logic [CNT_W-1:0]  cfg_max_len,
    output logic              res_valid,
    output logic              res_err,
    output logic [7:0]        res_code
);
    logic [CNT_W-1:0] cnt_prev, cnt_now;
    logic             rxerr_now, ovf_now;
    logic [15:0]      field_now;
    rxc_code_e        code_now;
    logic             valid_q;
    logic [7:0]       code_q;

    rxc_frame_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_rxerr(in_rxerr & in_valid), .in_ovf(in_ovf & in_valid),
        .cnt_prev(cnt_prev), .cnt_now(cnt_now),
        .rxerr_now(rxerr_now), .ovf_now(ovf_now)
    );

    rxc_len_field #(.CNT_W(CNT_W)) u_fld (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cnt_prev(cnt_prev), .field_now(field_now)
    );

    rxc_verdict #(.CNT_W(CNT_W), .SKIP_W(SKIP_W), .JABBER_LEN(JABBER_LEN)) u_vrd (
        .n_bytes(cnt_now), .ovf(ovf_now), .rxerr(rxerr_now),
        .fcs_ok(in_fcs_ok), .dribble(in_dribble), .field(field_now),
        .cfg_skip(cfg_skip), .cfg_min_len(cfg_min_len),
        .cfg_max_len(cfg_max_len), .code(code_now)
    );

    // Register the verdict on the last byte; zero it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            code_q  <= '0;
        end else begin
            valid_q <= in_valid && in_last;
            code_q  <= (in_valid && in_last) ? 8'(code_now) : 8'd0;
        end
    end

    // Drive the outputs.
    always_comb begin
        res_valid = valid_q;
        res_code  = code_q;
        res_err   = (code_q != 8'd0);
    end

    // R1: verdict follows a last byte by exactly one cycle.
    assert_verdict_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> res_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_last));
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_code == 8'd0 && !res_err));
    // R2: overflow on the last byte always reports partial.
    assert_partial_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && in_ovf) |=> (res_code == 8'd1));
endmodule

// File: tb/sim_rx_frame_classifier.sv
module sim_rx_frame_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_rxerr = 1'b0, in_ovf = 1'b0, in_last = 1'b0;
    logic        in_fcs_ok = 1'b1, in_dribble = 1'b0;
    logic [7:0]  in_data = '0;
    logic [7:0]  cfg_skip = 8'd0;
    logic [15:0] cfg_min_len = 16'd64, cfg_max_len = 16'd1518;
    logic        res_valid, res_err;
    logic [7:0]  res_code;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    rx_frame_classifier u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_rxerr(in_rxerr), .in_ovf(in_ovf), .in_last(in_last),
        .in_fcs_ok(in_fcs_ok), .in_dribble(in_dribble), .cfg_skip(cfg_skip),
        .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
        .res_valid(res_valid), .res_err(res_err), .res_code(res_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: push the expected code, then drive the frame bytes.
    task automatic send(input int len, input bit fcs, input bit drib,
                        input int rxe_at, input int ovf_at,
                        input logic [15:0] fld, input logic [7:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        for (int i = 0; i < len; i++) begin
            in_valid   = 1'b1;
            in_data    = (i == 12) ? fld[15:8] : (i == 13) ? fld[7:0] : 8'(i);
            in_rxerr   = (i == rxe_at);
            in_ovf     = (i == ovf_at);
            in_last    = (i == len - 1);
            in_fcs_ok  = fcs;
            in_dribble = drib;
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_last = 1'b0; in_rxerr = 1'b0; in_ovf = 1'b0;
        in_dribble = 1'b0; in_fcs_ok = 1'b1;
    endtask

    // Monitor: pop and compare each verdict; R1 idle outputs stay zero.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected verdict", res_code, -1);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(res_code == e, t, res_code, e);
                    check(res_err == (e != 0), {t, " R1 err flag"}, res_err, e != 0);
                end
            end else if (res_code != 0 || res_err) begin
                check(1'b0, "R1 idle outputs", res_code, 0);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(res_valid == 0 && res_code == 0 && res_err == 0, "R1 reset state", res_code, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R11 clean and FCS-only
        send(64, 1, 0, -1, -1, 16'h0800, 8'd0, "R11 clean frame");
        send(64, 0, 0, -1, -1, 16'h0800, 8'd7, "R11 fcs error");
        // R5 just over max, both FCS states; max itself is fine
        send(1519, 0, 0, -1, -1, 16'h0800, 8'd3, "R5 overrun");
        send(1519, 1, 0, -1, -1, 16'h0800, 8'd4, "R5 oversize");
        send(1518, 1, 0, -1, -1, 16'h0800, 8'd0, "R5 at max");
        // R3 truncation limit
        send(1537, 1, 0, -1, -1, 16'h0800, 8'd2, "R3 truncated");
        send(1536, 1, 0, -1, -1, 16'h0800, 8'd4, "R3 at limit");
        // R7 below min
        send(63, 0, 0, -1, -1, 16'h0800, 8'd6, "R7 fragment");
        send(63, 1, 0, -1, -1, 16'h0800, 8'd8, "R7 undersize");
        // R6 dribble
        send(64, 0, 1, -1, -1, 16'h0800, 8'd5, "R6 alignment");
        send(64, 1, 1, -1, -1, 16'h0800, 8'd0, "R6 dribble good fcs ignored");
        // R4 receive error and R12 priorities
        send(64, 1, 0, 5, -1, 16'h0800, 8'd11, "R4 rx error");
        send(1519, 0, 0, 0, -1, 16'h0800, 8'd11, "R12 rxerr over overrun");
        send(1537, 0, 0, 7, 3, 16'h0800, 8'd1, "R2 partial over truncated");
        send(40, 0, 1, -1, -1, 16'h0800, 8'd5, "R12 alignment over fragment");
        send(64, 1, 0, -1, 63, 16'h0800, 8'd1, "R2 overflow on last byte");
        // R13 clean frame straight after faulty ones
        send(64, 1, 0, -1, -1, 16'h0800, 8'd0, "R13 no carry-over");
        // R10 length field
        send(64, 1, 0, -1, -1, 16'd46, 8'd0, "R10 length matches");
        send(64, 1, 0, -1, -1, 16'd40, 8'd10, "R10 length mismatch");
        send(64, 1, 0, -1, -1, 16'h05FF, 8'd10, "R10 field 0x05FF checked");
        send(70, 1, 0, -1, -1, 16'h0600, 8'd0, "R10 field 0x0600 is a type");
        send(64, 0, 0, -1, -1, 16'd40, 8'd10, "R12 mismatch over fcs");
        // R8, R9 with a small minimum
        @(posedge clk); #1;
        cfg_min_len = 16'd4;
        cfg_skip    = 8'd20;
        send(10, 0, 0, -1, -1, 16'h0800, 8'd12, "R8 skip short");
        send(19, 1, 0, -1, -1, 16'h0800, 8'd12, "R8 skip one short");
        send(20, 1, 0, -1, -1, 16'h0800, 8'd0, "R8 skip covered");
        cfg_skip = 8'd0;
        send(13, 1, 0, -1, -1, 16'h0800, 8'd18, "R9 L2 short");
        send(14, 1, 0, -1, -1, 16'h0800, 8'd0, "R9 header complete");
        send(3, 1, 0, -1, -1, 16'h0800, 8'd8, "R12 undersize over L2 short");
        repeat (4) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R1 all verdicts seen", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule